// File: doc/BRIEF.md
# Splittable Bidirectional Row Scan Register

This block is the row-scan path of a panel driver. It holds one bit per row line and moves the whole pattern one place on every falling edge of the scan clock. A single mode pin decides whether the register acts as one long chain or as two equal chains that shift side by side. A direction pin decides which end of the register takes in new data and which end passes data out.

The two end pins swap roles with direction. When shifting upward (toward the highest index), the low-end pin is an input and the high-end pin drives out the bit that leaves the top. When shifting downward, the high-end pin is the input and the low-end pin drives out the bit that leaves the bottom. In split mode a separate middle input feeds the half-chain that starts at the centre, so two scan sequences can run at once. The full register is presented in parallel to the output stage. Row index 0 is the first line and index WIDTH-1 the last.

Top module: `row_scan_shifter`

## Requirements
- R1: While `rst_n` is low the register holds all zeros, and it still holds all zeros at the first falling scan edge after reset.
- R2: With `dual_mode`=0 and `shift_right`=1, each falling edge moves bit i to bit i+1 for every i below WIDTH-1 and loads `eio1_in` into bit 0.
- R3: With `dual_mode`=0 and `shift_right`=0, each falling edge moves bit i to bit i-1 for every i above 0 and loads `eio2_in` into bit WIDTH-1.
- R4: With `dual_mode`=1 and `shift_right`=1, the lower half shifts upward fed by `eio1_in` at bit 0, and the upper half shifts upward fed by `mid_in` at bit WIDTH/2.
- R5: With `dual_mode`=1 and `shift_right`=0, the upper half shifts downward fed by `eio2_in` at bit WIDTH-1, and the lower half shifts downward fed by `mid_in` at bit WIDTH/2-1.
- R6: With `dual_mode`=0, `mid_in` has no effect on the register contents.
- R7: With `shift_right`=1, `eio2_oe`=1, `eio1_oe`=0, `eio2_out` equals bit WIDTH-1 and `eio1_out`=0; with `shift_right`=0 the roles swap, `eio1_out` equals bit 0 and `eio2_out`=0.
- R8: In split mode no bit crosses the centre: a bit walking through one half leaves the register after WIDTH/2 edges without ever appearing in the other half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Scan clock; the register shifts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| dual_mode | input | 1 | 0: one chain of WIDTH bits; 1: two chains of WIDTH/2 bits |
| shift_right | input | 1 | 1: shift toward the highest index; 0: toward index 0 |
| mid_in | input | 1 | Data input of the centre-started half-chain in split mode |
| eio1_in | input | 1 | Low-end pin input value (used when shifting upward) |
| eio1_out | output | 1 | Low-end pin output value (bit 0 when shifting downward) |
| eio1_oe | output | 1 | Low-end pin output enable |
| eio2_in | input | 1 | High-end pin input value (used when shifting downward) |
| eio2_out | output | 1 | High-end pin output value (bit WIDTH-1 when shifting upward) |
| eio2_oe | output | 1 | High-end pin output enable |
| rows | output | WIDTH | Parallel register contents for the output stage |

## Verification
The bench builds the block with WIDTH=16, so each half-chain is 8 bits long. This keeps every one of the four topologies walkable end to end in a few dozen edges, with a single 1 injected either at an end pin or at the centre input, and puts the centre split and both far ends within reach of every walk. Holding the centre input high through the single-chain walks shows it is ignored, and the empty register after each half-chain walk shows that nothing leaks across the split.

// File: rtl/row_scan_shifter.sv
module row_scan_shifter #(
  parameter int WIDTH = 240
) (
  input  logic             scan_clk,
  input  logic             rst_n,
  input  logic             dual_mode,
  input  logic             shift_right,
  input  logic             mid_in,
  input  logic             eio1_in,
  output logic             eio1_out,
  output logic             eio1_oe,
  input  logic             eio2_in,
  output logic             eio2_out,
  output logic             eio2_oe,
  output logic [WIDTH-1:0] rows
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] nxt;

  always_comb begin
    if (shift_right) begin
      nxt       = {rows[WIDTH-2:0], eio1_in};
      nxt[HALF] = dual_mode ? mid_in : rows[HALF-1];
    end else begin
      nxt         = {eio2_in, rows[WIDTH-1:1]};
      nxt[HALF-1] = dual_mode ? mid_in : rows[HALF];
    end
  end

  always_ff @(negedge scan_clk or negedge rst_n)
    if (!rst_n) rows <= '0;
    else        rows <= nxt;

  assign eio2_oe  = shift_right;
  assign eio1_oe  = !shift_right;
  assign eio2_out = shift_right & rows[WIDTH-1];
  assign eio1_out = !shift_right & rows[0];
endmodule

// File: rtl/row_scan_shifter_chk.sv
module row_scan_shifter_chk #(
  parameter int WIDTH = 240
) (
  input logic             scan_clk,
  input logic             rst_n,
  input logic             dual_mode,
  input logic             shift_right,
  input logic             mid_in,
  input logic             eio1_in,
  input logic             eio1_out,
  input logic             eio1_oe,
  input logic             eio2_in,
  input logic             eio2_out,
  input logic             eio2_oe,
  input logic [WIDTH-1:0] rows
);
  localparam int HALF = WIDTH / 2;

  p_clear_r1: assert property (@(negedge scan_clk) !rst_n |=> rows == '0);

  p_single_up_r2: assert property (@(negedge scan_clk) disable iff (!rst_n)
    (!dual_mode && shift_right) |=> rows == {$past(rows[WIDTH-2:0]), $past(eio1_in)});

  p_single_down_r3: assert property (@(negedge scan_clk) disable iff (!rst_n)
    (!dual_mode && !shift_right) |=> rows == {$past(eio2_in), $past(rows[WIDTH-1:1])});

  p_dual_up_r4: assert property (@(negedge scan_clk) disable iff (!rst_n)
    (dual_mode && shift_right) |=>
      (rows[HALF-1:0] == {$past(rows[HALF-2:0]), $past(eio1_in)}) &&
      (rows[WIDTH-1:HALF] == {$past(rows[WIDTH-2:HALF]), $past(mid_in)}));

  p_dual_down_r5: assert property (@(negedge scan_clk) disable iff (!rst_n)
    (dual_mode && !shift_right) |=>
      (rows[WIDTH-1:HALF] == {$past(eio2_in), $past(rows[WIDTH-1:HALF+1])}) &&
      (rows[HALF-1:0] == {$past(mid_in), $past(rows[HALF-1:1])}));

  p_pin_roles_r7: assert property (@(negedge scan_clk) disable iff (!rst_n)
    $onehot0({eio1_oe, eio2_oe}) && (eio1_oe != eio2_oe) &&
    (eio2_oe ? (eio2_out == rows[WIDTH-1] && !eio1_out)
             : (eio1_out == rows[0] && !eio2_out)));
endmodule

bind row_scan_shifter row_scan_shifter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_row_scan_shifter.sv
module tb_row_scan_shifter;
  localparam int W = 16;
  localparam int H = W / 2;

  logic scan_clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_mode = 1'b0, shift_right = 1'b1, mid_in = 1'b0;
  logic eio1_in = 1'b0, eio2_in = 1'b0;
  logic eio1_out, eio1_oe, eio2_out, eio2_oe;
  logic [W-1:0] rows;

  int checks = 0;
  int errors = 0;

  row_scan_shifter #(.WIDTH(W)) dut (
    .scan_clk(scan_clk), .rst_n(rst_n), .dual_mode(dual_mode),
    .shift_right(shift_right), .mid_in(mid_in),
    .eio1_in(eio1_in), .eio1_out(eio1_out), .eio1_oe(eio1_oe),
    .eio2_in(eio2_in), .eio2_out(eio2_out), .eio2_oe(eio2_oe),
    .rows(rows));

  always #2.5 scan_clk = ~scan_clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge scan_clk);
    #1;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    step(); step(); step();
    check("R1 rows in reset", rows, 0);
    check("R1 eio2_out in reset", eio2_out, 0);
    rst_n = 1'b1;
    step();
    check("R1 rows after release", rows, 0);
  endtask

  // from_mid=0: pulse the end pin; from_mid=1: pulse mid_in (split mode only)
  task automatic walk(input string req, input logic dual, input logic right, input logic from_mid);
    int start, len, far;
    logic [W-1:0] one;
    one = 1;
    len = dual ? H : W;
    far = right ? W - 1 : 0;
    if (right) start = from_mid ? H : 0;
    else       start = from_mid ? H - 1 : W - 1;
    dual_mode = dual; shift_right = right;
    eio1_in = 1'b0; eio2_in = 1'b0;
    mid_in = dual ? 1'b0 : 1'b1;  // held high in single mode: R6
    step();
    check({req, " R7 eio1_oe"}, eio1_oe, !right);
    check({req, " R7 eio2_oe"}, eio2_oe, right);
    if (from_mid) mid_in = 1'b1;
    else if (right) eio1_in = 1'b1;
    else eio2_in = 1'b1;
    for (int s = 0; s < len; s++) begin
      int pos;
      step();
      if (from_mid) mid_in = 1'b0;
      eio1_in = 1'b0; eio2_in = 1'b0;
      pos = right ? start + s : start - s;
      check(req, rows, one << pos);
      if (right) begin
        check({req, " R7 eio2_out"}, eio2_out, pos == far);
        check({req, " R7 eio1_out"}, eio1_out, 0);
      end else begin
        check({req, " R7 eio1_out"}, eio1_out, pos == far);
        check({req, " R7 eio2_out"}, eio2_out, 0);
      end
    end
    step();
    check({req, dual ? " R8 empty after half walk" : " empty after full walk"}, rows, 0);
  endtask

  initial begin
    test_reset();
    walk("R2 R6 single up",      1'b0, 1'b1, 1'b0);
    walk("R3 R6 single down",    1'b0, 1'b0, 1'b0);
    walk("R4 dual up low half",  1'b1, 1'b1, 1'b0);
    walk("R4 dual up mid half",  1'b1, 1'b1, 1'b1);
    walk("R5 dual down top half",1'b1, 1'b0, 1'b0);
    walk("R5 dual down mid half",1'b1, 1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule